// File: doc/BRIEF.md
# Serial Register-Map Slave with Counter Snapshot

This block is the two-wire serial slave that fronts a 256-entry byte map of registers and RAM. It watches the synchronized clock and data lines and picks out start and stop conditions. It accepts a 7-bit device address in which one bit comes from a select pin. The first byte of a write transfer is taken as a word pointer. The block then stores or returns bytes at successive pointer values. The map itself sits outside the block. The block drives it through a pointer address, a write-data byte, a one-cycle write enable and a combinational read-data return.

The pointer is kept after a transfer ends, so a read that follows only an address byte goes on from where the last access stopped. A read can also follow a pointer write through a repeated start. Each read transfer begins with a one-cycle snapshot strobe. The register file uses it to freeze its running counters into capture latches, so that a multi-byte read sees one consistent time. The bus lines are sampled in a system clock at least eight times faster than the serial clock. The data line is driven low through an enable output, and the pad is outside the block.

Top module: `i2c_regmap_slave`

## Requirements
- R1: After reset the data-line drive enable, the write enable and the snapshot strobe are low, and the pointer address is 00h.
- R2: An address byte of 1010_00, then the select pin value, then the R/W bit (0 = write, 1 = read), is acknowledged by driving the data line low through the ninth clock. So 0xA0/0xA2 select a write and 0xA1/0xA3 select a read, for select = 0/1.
- R3: An address byte that does not match is not acknowledged. The data line then stays released, with no write and no strobe, until the next start.
- R4: In a write transfer the first byte after the address loads the pointer and is acknowledged, but it is not stored.
- R5: Each later byte of a write transfer is stored at the pointer with a one-cycle write enable and acknowledged, and the pointer then steps by one, wrapping from FFh to 00h.
- R6: A read after a repeated start returns data from the pointer just written. A read sent straight after its address byte returns data from the pointer as left by earlier transfers, including ones that ended with a stop.
- R7: The pointer steps by one after every byte read, so successive read bytes come from successive locations, wrapping from FFh to 00h.
- R8: After the master answers a read byte with a not-acknowledge, the slave leaves the data line released until the next start.
- R9: A matching read address makes the snapshot strobe high for exactly one system clock, once per read transfer, before the first data bit is driven.
- R10: The select pin picks the device address. With select high, 0xA2/0xA3 are answered and 0xA0 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High to pull the data line low |
| sel_i | input | 1 | Address select bit (bit 1 of the address byte) |
| reg_addr_o | output | 8 | Word pointer, used as the register-file address |
| reg_wdata_o | output | 8 | Byte to store |
| reg_we_o | output | 1 | One-cycle store strobe at reg_addr_o |
| reg_rdata_i | input | 8 | Combinational read data at reg_addr_o |
| snap_o | output | 1 | One-cycle counter-capture strobe at the start of a read |

## Verification
The strobes that can land in the same cycle are the pointer step after a stored byte and the capture of a read byte: each updates the pointer. The snapshot strobe and the store strobe also meet in a write-then-read transfer, where one follows the other across a repeated start. The bench provokes this with a pointer write, a data write at FEh–FFh that runs over the wrap, and then a repeated-start read of the freshly written and wrapped locations. It judges the result by the bytes returned, by the bench's own model memory and by the captured counter value. A live 16-bit counter behind locations 01h/02h changes every clock, so a missing or late snapshot shows up as a byte pair that differs from the captured value.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_PTR,
        ST_PACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign dout[b] = chain_q[LAST];
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign start_o = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_o  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
    assign rise_o  = scl_s & ~prev_q.scl;
    assign fall_o  = ~scl_s & prev_q.scl;
endmodule

// File: rtl/i2c_regmap_core.sv
module i2c_regmap_core
    import i2c_regmap_pkg::*;
#(
    parameter int          AW     = 8,
    parameter logic [5:0]  DEV_ID = 6'b101000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sda_s,
    input  logic              sel_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [AW-1:0]     ptr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              we_o,
    output logic              oe_o,
    output logic              snap_o
);
    localparam logic [AW-1:0] PTR_ONE  = AW'(1);
    localparam logic [3:0]    BITS_END = 4'd8;
    localparam logic [3:0]    BIT_LAST = 4'd7;

    typedef struct packed {
        slv_state_e        state;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [AW-1:0]     ptr;
        logic [BYTE_W-1:0] wdata;
        logic              we;
        logic              oe;
        logic              snap;
        logic              rw;
        logic              mack;
    } core_t;

    core_t d, q;
    logic [BYTE_W-1:0] rx_byte;
    logic              id_hit_rx;
    logic              id_hit_sh;

    assign rx_byte   = {q.sh[BYTE_W-2:0], sda_s};
    assign id_hit_rx = (rx_byte[BYTE_W-1:1] == {DEV_ID, sel_i});
    assign id_hit_sh = (q.sh[BYTE_W-1:1] == {DEV_ID, sel_i});

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.snap = 1'b0;
        if (q.we) d.ptr = q.ptr + PTR_ONE;

        if (start_i) begin
            d.state = ST_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else if (stop_i) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR, ST_PTR, ST_WDAT: begin
                    if (rise_i && q.cnt != BITS_END) begin
                        d.sh  = rx_byte;
                        d.cnt = q.cnt + 4'd1;
                        if (q.state == ST_ADDR && q.cnt == BIT_LAST && id_hit_rx && rx_byte[0])
                            d.snap = 1'b1;
                    end else if (fall_i && q.cnt == BITS_END) begin
                        case (q.state)
                            ST_ADDR: begin
                                if (id_hit_sh) begin
                                    d.oe    = 1'b1;
                                    d.rw    = q.sh[0];
                                    d.state = ST_AACK;
                                end else begin
                                    d.state = ST_IDLE;
                                end
                            end
                            ST_PTR: begin
                                d.oe    = 1'b1;
                                d.ptr   = q.sh[AW-1:0];
                                d.state = ST_PACK;
                            end
                            default: begin
                                d.oe    = 1'b1;
                                d.we    = 1'b1;
                                d.wdata = q.sh;
                                d.state = ST_WACK;
                            end
                        endcase
                    end
                end
                ST_AACK: begin
                    if (fall_i) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh    = rdata_i;
                            d.ptr   = q.ptr + PTR_ONE;
                            d.oe    = ~rdata_i[BYTE_W-1];
                            d.state = ST_RDAT;
                        end else begin
                            d.oe    = 1'b0;
                            d.state = ST_PTR;
                        end
                    end
                end
                ST_PACK, ST_WACK: begin
                    if (fall_i) begin
                        d.oe    = 1'b0;
                        d.cnt   = '0;
                        d.state = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (rise_i) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall_i) begin
                        if (q.cnt == BITS_END) begin
                            d.oe    = 1'b0;
                            d.state = ST_RACK;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b1};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (rise_i) begin
                        d.mack = sda_s;
                    end else if (fall_i) begin
                        if (!q.mack) begin
                            d.cnt   = '0;
                            d.sh    = rdata_i;
                            d.ptr   = q.ptr + PTR_ONE;
                            d.oe    = ~rdata_i[BYTE_W-1];
                            d.state = ST_RDAT;
                        end else begin
                            d.oe    = 1'b0;
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.sh    <= '1;
            q.mack  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ptr_o   = q.ptr;
    assign wdata_o = q.wdata;
    assign we_o    = q.we;
    assign oe_o    = q.oe;
    assign snap_o  = q.snap;
endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave #(
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_ID      = 6'b101000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    input  logic          sel_i,
    output logic [AW-1:0] reg_addr_o,
    output logic [7:0]    reg_wdata_o,
    output logic          reg_we_o,
    input  logic [7:0]    reg_rdata_i,
    output logic          snap_o
);
    logic scl_s, sda_s;
    logic ev_start, ev_stop, ev_rise, ev_fall;

    i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout ({scl_s, sda_s})
    );

    i2c_bus_events u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s  (scl_s),
        .sda_s  (sda_s),
        .start_o(ev_start),
        .stop_o (ev_stop),
        .rise_o (ev_rise),
        .fall_o (ev_fall)
    );

    i2c_regmap_core #(.AW(AW), .DEV_ID(DEV_ID)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(ev_start),
        .stop_i (ev_stop),
        .rise_i (ev_rise),
        .fall_i (ev_fall),
        .sda_s  (sda_s),
        .sel_i  (sel_i),
        .rdata_i(reg_rdata_i),
        .ptr_o  (reg_addr_o),
        .wdata_o(reg_wdata_o),
        .we_o   (reg_we_o),
        .oe_o   (sda_oe_o),
        .snap_o (snap_o)
    );
endmodule

// File: rtl/i2c_regmap_slave_chk.sv
module i2c_regmap_slave_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input logic          reg_we,
    input logic          snap,
    input logic [AW-1:0] reg_addr
);
    // R9
    snap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> !snap);

    // R5
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + AW'(1)));

    // R9
    snap_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(snap && reg_we));

    // R2
    drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_regmap_slave i2c_regmap_slave_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_oe  (sda_oe_o),
    .reg_we  (reg_we_o),
    .snap    (snap_o),
    .reg_addr(reg_addr_o)
);

// File: tb/i2c_regmap_slave_bench.sv
`timescale 1ns/1ps
module i2c_regmap_slave_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, sel = 1'b0;
    logic sda_oe, we, snap;
    logic [7:0] addr, wdata, rdata;
    wire sda_bus = sda_m & ~sda_oe;

    int compared = 0, mismatched = 0;
    logic quiet = 1'b0;
    logic [7:0] mem [256];
    logic [15:0] live = 16'h1234, cap = 16'h0;
    int snaps = 0, writes = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_regmap_slave u_i2c_regmap_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .sel_i(sel), .reg_addr_o(addr),
        .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata), .snap_o(snap));

    // register-file model: 01h/02h return the captured live counter
    assign rdata = (addr == 8'h01) ? cap[7:0] : (addr == 8'h02) ? cap[15:8] : mem[addr];

    always @(posedge clk) begin
        live <= live + 16'd37;
        if (we) begin mem[addr] <= wdata; writes <= writes + 1; end
        if (snap) begin cap <= live; snaps <= snaps + 1; end
    end

    // per-clock reference of the released windows (R3, R8)
    always @(negedge clk) if (quiet && !finished) begin
        compared++;
        if (sda_oe) begin
            mismatched++;
            $display("FAIL R3/R8 drive in released window: actual %0b expected 0", sda_oe);
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bit_io(input logic b, output logic s);
        sda_m = b; wq(); scl_m = 1'b1; wq(); s = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic last, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); v[i] = s; end
        bit_io(last, s);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int s0, w0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 oe", 16'(sda_oe), 0);
        chk("R1 we", 16'(we), 0);
        chk("R1 snap", 16'(snap), 0);
        chk("R1 addr", 16'(addr), 0);

        // R2 R4 R5: write pointer 10h then four bytes
        m_start();
        wr_byte(8'hA0, ack); chk("R2 addr ack", 16'(ack), 1);
        wr_byte(8'h10, ack); chk("R4 ptr ack", 16'(ack), 1);
        wr_byte(8'h11, ack); chk("R5 data ack", 16'(ack), 1);
        wr_byte(8'h22, ack);
        wr_byte(8'h33, ack);
        wr_byte(8'h5A, ack);
        m_stop();
        chk("R4 ptr byte not stored", 16'(mem[0]), 0);
        chk("R5 mem10", 16'(mem[8'h10]), 16'h11);
        chk("R5 mem11", 16'(mem[8'h11]), 16'h22);
        chk("R5 mem12", 16'(mem[8'h12]), 16'h33);
        chk("R5 mem13", 16'(mem[8'h13]), 16'h5A);
        chk("R5 write count", 16'(writes), 4);

        // R3 R10: 0xA2 with select low is ignored
        s0 = snaps; w0 = writes;
        quiet = 1'b1;
        m_start();
        wr_byte(8'hA2, ack); chk("R3 no ack", 16'(ack), 0);
        wr_byte(8'h00, ack); chk("R3 still released", 16'(ack), 0);
        m_stop();
        quiet = 1'b0;
        chk("R3 no write", 16'(writes - w0), 0);
        chk("R3 no snap", 16'(snaps - s0), 0);

        // R6 R7 R8 R9: pointer write, repeated start, read three
        s0 = snaps;
        m_start();
        wr_byte(8'hA0, ack);
        wr_byte(8'h10, ack);
        m_start();
        wr_byte(8'hA1, ack); chk("R2 read addr ack", 16'(ack), 1);
        chk("R9 one snap", 16'(snaps - s0), 1);
        rd_byte(1'b0, v); chk("R6 rd10", 16'(v), 16'h11);
        rd_byte(1'b0, v); chk("R7 rd11", 16'(v), 16'h22);
        rd_byte(1'b1, v); chk("R7 rd12", 16'(v), 16'h33);
        quiet = 1'b1;
        wq(); wq();
        m_stop();
        quiet = 1'b0;
        chk("R9 still one snap", 16'(snaps - s0), 1);

        // R6: direct read continues at 13h after the stop
        m_start();
        wr_byte(8'hA1, ack);
        rd_byte(1'b1, v); chk("R6 persisted ptr", 16'(v), 16'h5A);
        m_stop();

        // R5 wrap: FEh..00h
        m_start();
        wr_byte(8'hA0, ack);
        wr_byte(8'hFE, ack);
        wr_byte(8'hAA, ack);
        wr_byte(8'hBB, ack);
        wr_byte(8'hCC, ack);
        m_stop();
        chk("R5 memFE", 16'(mem[8'hFE]), 16'hAA);
        chk("R5 memFF", 16'(mem[8'hFF]), 16'hBB);
        chk("R5 wrap mem00", 16'(mem[8'h00]), 16'hCC);

        // R7 wrap on read
        m_start();
        wr_byte(8'hA0, ack);
        wr_byte(8'hFF, ack);
        m_start();
        wr_byte(8'hA1, ack);
        rd_byte(1'b0, v); chk("R7 rdFF", 16'(v), 16'hBB);
        rd_byte(1'b1, v); chk("R7 wrap rd00", 16'(v), 16'hCC);
        m_stop();

        // R9: snapshot consistency of the live counter
        s0 = snaps;
        m_start();
        wr_byte(8'hA0, ack);
        wr_byte(8'h01, ack);
        m_start();
        wr_byte(8'hA1, ack);
        rd_byte(1'b0, v); chk("R9 snap lo", 16'(v), 16'(cap[7:0]));
        rd_byte(1'b1, v); chk("R9 snap hi", 16'(v), 16'(cap[15:8]));
        m_stop();
        chk("R9 snap count", 16'(snaps - s0), 1);
        chk("R9 cap nonzero", 16'(cap != 16'h0), 1);

        // R10: select high
        sel = 1'b1;
        quiet = 1'b1;
        m_start();
        wr_byte(8'hA0, ack); chk("R10 A0 ignored", 16'(ack), 0);
        m_stop();
        quiet = 1'b0;
        m_start();
        wr_byte(8'hA2, ack); chk("R10 A2 ack", 16'(ack), 1);
        wr_byte(8'h40, ack);
        wr_byte(8'h77, ack);
        m_stop();
        chk("R10 mem40", 16'(mem[8'h40]), 16'h77);
        m_start();
        wr_byte(8'hA3, ack); chk("R10 A3 ack", 16'(ack), 1);
        rd_byte(1'b1, v); chk("R10 rd41", 16'(v), 16'(mem[8'h41]));
        m_stop();

        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule